// File: doc/BRIEF.md
# System Status and Control Register with Sleep Interlock

This block is the byte-wide status and control register of a small microcontroller. It records which kind of reset last hit the chip: power-on or external, or watchdog. It also holds a latch that can only be cleared, and clearing it switches the watchdog on for good.

Software uses the same byte to control power. It can set a sleep request bit, or a stop bit that halts execution until the next reset. Bit 7 is a read-only copy of the processor's global interrupt enable.

The sleep bit guards itself in two ways:
- A write that would set it is dropped when an enabled interrupt is being taken on that same cycle.
- Once the bit is set, an interrupt cannot clear it until the power-down sequence reports completion.

An interrupt that arrives inside that window is held. It wakes the system one cycle after power-down is seen.

The power-on/external reset is the asynchronous active-low input `por_n`. The watchdog reset is a synchronous one-cycle pulse on `wdr_i`. A register write takes effect on the rising clock edge of the cycle in which `wr_en` is high. Reads are combinational.

Top module: `sscr_top`

## Requirements
- R1: While `por_n` is low, and after it rises, the register reads 0x10 (bit 7 then follows `gie_i`). After a cycle with `wdr_i` high it reads 0x20. Both resets clear the sleep and stop bits.
- R2: Bit 5 is set by a `wdr_i` pulse. Writing 0 to bit 5 clears it. Writing 1 to bit 5 never sets it.
- R3: Bit 4 is set only by `por_n` low. Writing 0 to bit 4 clears it, and writing 1 has no effect. A watchdog reset leaves bit 4 at 0.
- R4: `wdt_en_o` is the inverse of bit 4, so once it is high it stays high until `por_n` goes low.
- R5: Bit 7 reads the current value of `gie_i`. Writes to bit 7 have no effect.
- R6: Writing 1 to bit 3 sets the sleep bit and `sleep_o` after the write edge. Writing 0 to bit 3 clears them.
- R7: A write of 1 to bit 3 in a cycle where `irq_i` is high, while the sleep bit is clear, leaves the sleep bit clear.
- R8: While the sleep bit is set, `irq_i` does not clear it until `pwrdn_i` has been sampled high. An interrupt seen earlier is held. The sleep bit then clears on the edge after the one that sampled `pwrdn_i` high. If no interrupt is held, it clears on the first edge after that with `irq_i` high.
- R9: Bit 0 (`stop_o`) is written from bit 0 of the write data and stays set until a write of 0 or either reset.
- R10: Bits 6, 2 and 1 always read 0, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on/external reset, asynchronous, active low |
| wdr_i | input | 1 | Watchdog reset pulse, synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| gie_i | input | 1 | Global interrupt enable flag of the CPU |
| irq_i | input | 1 | An enabled interrupt is being taken |
| pwrdn_i | input | 1 | Sleep sequence finished, system power-down asserted |
| wdt_en_o | output | 1 | Watchdog enable |
| sleep_o | output | 1 | Sleep request |
| stop_o | output | 1 | CPU stop |

## Verification
The bench lines up an interrupt with the sleep write on the same cycle. A design without the block would enter sleep with an interrupt already being serviced.

It raises an interrupt between the sleep request and power-down, then checks the exact cycle of the wake. A missing interlock wakes too early, and a lost pending interrupt never wakes at all.

It tries to set bits 4 and 5 and bit 7 from software. A faulty design would switch the watchdog back off, or invent a reset cause.

It also compares the read value after each reset type, so swapped or merged reset images show up at once.

// File: rtl/sscr_pkg.sv
package sscr_pkg;
  localparam int REG_W   = 8;
  localparam int B_GIE   = 7;
  localparam int B_WDRS  = 5;
  localparam int B_PORS  = 4;
  localparam int B_SLEEP = 3;
  localparam int B_STOP  = 0;

  typedef struct packed {
    logic gie;
    logic wdrs;
    logic pors;
    logic sleep;
    logic stop;
  } sscr_fields_t;

  function automatic logic [REG_W-1:0] pack_read(sscr_fields_t f);
    logic [REG_W-1:0] v;
    v = '0;
    v[B_GIE]   = f.gie;
    v[B_WDRS]  = f.wdrs;
    v[B_PORS]  = f.pors;
    v[B_SLEEP] = f.sleep;
    v[B_STOP]  = f.stop;
    return v;
  endfunction
endpackage

// File: rtl/sscr_reset_flags.sv
module sscr_reset_flags (
  input  logic clk,
  input  logic por_n,
  input  logic wdr_i,
  input  logic wr_en,
  input  logic wr_wdrs,
  input  logic wr_pors,
  output logic wdrs_q,
  output logic pors_q
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wdrs_q <= 1'b0;
      pors_q <= 1'b1;
    end else if (wdr_i) begin
      wdrs_q <= 1'b1;
      pors_q <= 1'b0;
    end else if (wr_en) begin
      if (!wr_wdrs) wdrs_q <= 1'b0;
      if (!wr_pors) pors_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sscr_sleep_ctl.sv
module sscr_sleep_ctl (
  input  logic clk,
  input  logic por_n,
  input  logic wdr_i,
  input  logic wr_en,
  input  logic wr_sleep,
  input  logic irq_i,
  input  logic pwrdn_i,
  output logic sleep_q,
  output logic pwrdn_seen_q,
  output logic irq_held_q,
  output logic set_blocked,
  output logic wake_fire
);
  logic sleep_d, seen_d, held_d;

  assign set_blocked = wr_en & wr_sleep & irq_i & ~sleep_q;
  assign wake_fire   = sleep_q & pwrdn_seen_q & (irq_i | irq_held_q);

  always_comb begin
    sleep_d = sleep_q;
    seen_d  = pwrdn_seen_q;
    held_d  = irq_held_q;
    if (sleep_q) begin
      if (pwrdn_i) seen_d = 1'b1;
      if (irq_i && !pwrdn_seen_q) held_d = 1'b1;
    end
    if (wdr_i || wake_fire || (wr_en && !wr_sleep)) begin
      sleep_d = 1'b0;
      seen_d  = 1'b0;
      held_d  = 1'b0;
    end else if (wr_en && wr_sleep && !irq_i) begin
      sleep_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sleep_q      <= 1'b0;
      pwrdn_seen_q <= 1'b0;
      irq_held_q   <= 1'b0;
    end else begin
      sleep_q      <= sleep_d;
      pwrdn_seen_q <= seen_d;
      irq_held_q   <= held_d;
    end
  end
endmodule

// File: rtl/sscr_top.sv
module sscr_top
  import sscr_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             wdr_i,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             gie_i,
  input  logic             irq_i,
  input  logic             pwrdn_i,
  output logic             wdt_en_o,
  output logic             sleep_o,
  output logic             stop_o
);
  logic wdrs_q, pors_q, sleep_q, stop_q;
  logic pwrdn_seen_q, irq_held_q, set_blocked, wake_fire;
  sscr_fields_t fields;

  sscr_reset_flags u_flags (
    .clk(clk), .por_n(por_n), .wdr_i(wdr_i), .wr_en(wr_en),
    .wr_wdrs(wr_data[B_WDRS]), .wr_pors(wr_data[B_PORS]),
    .wdrs_q(wdrs_q), .pors_q(pors_q)
  );

  sscr_sleep_ctl u_sleep (
    .clk(clk), .por_n(por_n), .wdr_i(wdr_i), .wr_en(wr_en),
    .wr_sleep(wr_data[B_SLEEP]), .irq_i(irq_i), .pwrdn_i(pwrdn_i),
    .sleep_q(sleep_q), .pwrdn_seen_q(pwrdn_seen_q), .irq_held_q(irq_held_q),
    .set_blocked(set_blocked), .wake_fire(wake_fire)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      stop_q <= 1'b0;
    else if (wdr_i)  stop_q <= 1'b0;
    else if (wr_en)  stop_q <= wr_data[B_STOP];
  end

  always_comb begin
    fields.gie   = gie_i;
    fields.wdrs  = wdrs_q;
    fields.pors  = pors_q;
    fields.sleep = sleep_q;
    fields.stop  = stop_q;
  end

  assign rd_data  = pack_read(fields);
  assign wdt_en_o = ~pors_q;
  assign sleep_o  = sleep_q;
  assign stop_o   = stop_q;
endmodule

// File: rtl/sscr_chk.sv
module sscr_chk (
  input logic       clk,
  input logic       por_n,
  input logic       wdr_i,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       irq_i,
  input logic       wdt_en_o,
  input logic       sleep_o,
  input logic       stop_o,
  input logic       pwrdn_seen_q
);
  p_wdrs_no_sw_set_r2: assert property (@(posedge clk) disable iff (!por_n)
    (!rd_data[5] && !wdr_i) |=> !rd_data[5]);
  p_pors_one_way_r3: assert property (@(posedge clk) disable iff (!por_n)
    !rd_data[4] |=> !rd_data[4]);
  p_wdt_sticky_r4: assert property (@(posedge clk) disable iff (!por_n)
    wdt_en_o |=> wdt_en_o);
  p_sleep_blocked_r7: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && wr_data[3] && irq_i && !sleep_o) |=> !sleep_o);
  p_no_early_wake_r8: assert property (@(posedge clk) disable iff (!por_n)
    (sleep_o && !pwrdn_seen_q && !wdr_i && !(wr_en && !wr_data[3])) |=> sleep_o);
  p_stop_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
    (stop_o && !wdr_i && !(wr_en && !wr_data[0])) |=> stop_o);
  p_wdr_image_r1: assert property (@(posedge clk) disable iff (!por_n)
    wdr_i |=> (rd_data[5:0] == 6'h20 && !sleep_o && !stop_o));
endmodule

bind sscr_top sscr_chk u_chk (
  .clk(clk), .por_n(por_n), .wdr_i(wdr_i), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .irq_i(irq_i), .wdt_en_o(wdt_en_o), .sleep_o(sleep_o),
  .stop_o(stop_o), .pwrdn_seen_q(pwrdn_seen_q)
);

// File: tb/sscr_top_tb.sv
module sscr_top_tb;
  logic clk = 1'b0;
  logic por_n, wdr_i, wr_en, gie_i, irq_i, pwrdn_i;
  logic [7:0] wr_data, rd_data;
  logic wdt_en_o, sleep_o, stop_o;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  sscr_top u_dut (
    .clk(clk), .por_n(por_n), .wdr_i(wdr_i), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .gie_i(gie_i), .irq_i(irq_i), .pwrdn_i(pwrdn_i),
    .wdt_en_o(wdt_en_o), .sleep_o(sleep_o), .stop_o(stop_o)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d, input logic irq);
    wr_en = 1'b1; wr_data = d; irq_i = irq;
    tick();
    wr_en = 1'b0; wr_data = 8'h00; irq_i = 1'b0;
  endtask

  task automatic do_por();
    por_n = 1'b0; #3;
    chk(rd_data, 8'h10, "R1 during por");
    tick(); por_n = 1'b1; tick();
  endtask

  task automatic t_reset_values();
    do_por();
    chk(rd_data, 8'h10, "R1 after por");
    chk({7'b0, wdt_en_o}, 8'h00, "R4 wdt off after por");
    wr(8'h09, 1'b0);
    wdr_i = 1'b1; tick(); wdr_i = 1'b0;
    chk(rd_data, 8'h20, "R1 after wdr");
    chk({6'b0, sleep_o, stop_o}, 8'h00, "R1 wdr clears sleep/stop");
    chk({7'b0, wdt_en_o}, 8'h01, "R3 R4 wdr leaves wdt on");
  endtask

  task automatic t_flags();
    do_por();
    wr(8'hFF, 1'b0);
    chk(rd_data & 8'h66, 8'h00, "R10 unused bits / R2 no sw set");
    chk(rd_data, 8'h19, "R5 R6 R9 write all ones");
    wr(8'h10, 1'b0);
    chk(rd_data, 8'h10, "R9 R6 write zeros to stop/sleep");
    wr(8'h00, 1'b0);
    chk({7'b0, wdt_en_o}, 8'h01, "R4 wdt on after clear");
    wr(8'h10, 1'b0);
    chk(rd_data[4], 1'b0, "R3 sw cannot set bit4");
    gie_i = 1'b1; #1;
    chk(rd_data, 8'h80, "R5 gie mirror");
    wr(8'h00, 1'b0);
    chk(rd_data[7], 1'b1, "R5 write ignored");
    gie_i = 1'b0;
    wdr_i = 1'b1; tick(); wdr_i = 1'b0;
    wr(8'h00, 1'b0);
    chk(rd_data[5], 1'b0, "R2 clear by writing 0");
  endtask

  task automatic t_sleep_block();
    do_por();
    wr(8'h18, 1'b1);
    chk({7'b0, sleep_o}, 8'h00, "R7 write blocked by irq");
    wr(8'h18, 1'b0);
    chk({7'b0, sleep_o}, 8'h01, "R6 sleep set");
  endtask

  task automatic t_interlock();
    do_por();
    wr(8'h18, 1'b0);
    irq_i = 1'b1; tick(); irq_i = 1'b0;
    chk({7'b0, sleep_o}, 8'h01, "R8 irq held off");
    tick(); tick();
    chk({7'b0, sleep_o}, 8'h01, "R8 still asleep");
    pwrdn_i = 1'b1; tick(); pwrdn_i = 1'b0;
    chk({7'b0, sleep_o}, 8'h01, "R8 edge sampling pwrdn");
    tick();
    chk({7'b0, sleep_o}, 8'h00, "R8 held irq wakes");
    wr(8'h18, 1'b0);
    pwrdn_i = 1'b1; tick(); pwrdn_i = 1'b0;
    tick();
    chk({7'b0, sleep_o}, 8'h01, "R8 no irq stays asleep");
    irq_i = 1'b1; tick(); irq_i = 1'b0;
    chk({7'b0, sleep_o}, 8'h00, "R8 late irq wakes");
  endtask

  initial begin
    por_n = 1'b0; wdr_i = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    gie_i = 1'b0; irq_i = 1'b0; pwrdn_i = 1'b0;
    @(negedge clk);
    t_reset_values();
    t_flags();
    t_sleep_block();
    t_interlock();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule